// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block watches a received Ethernet frame as a byte stream and decides whether the frame is kept or discarded. It captures the six destination-address bytes and sorts the frame into unicast, broadcast or multicast. It then runs two filter stages in sequence. The first stage checks the frame against a station address, two reject controls and four multicast entries. The second stage is optional and checks against a second station address and a 32768-bit multicast hash table. Last, it applies two length rules. One drops frames that are too short. The other drops frames in the tagged-frame size band unless jumbo or tagged frames are allowed.

Software sets the block up through a word-wide register port with a one-cycle registered read. Registers sit at word addresses 0 to 8. The hash table occupies the upper half of the address space: it is selected by setting the top address bit, and the low 10 bits pick the table word. For every frame the block gives one decision pulse that carries an accept bit and a class code. It also keeps a sticky reject flag that software clears by writing a one to it.

Top module: `rx_addr_filter`

## Requirements
- R1: The first received byte is destination byte 0. The class is broadcast (code 2) when all six bytes are 0xFF. Otherwise it is unicast (code 0) when bit 0 of byte 0 is clear, and multicast (code 1) in every other case. Code 3 never appears.
- R2: A stored address is made of two words. Bytes 0–3 come from the low word, with byte 0 in bits 7:0. Bytes 4–5 come from bits 15:0 of the high word. In the first stage, a unicast frame passes only if it equals the station address (low word at address 1, high word at address 2).
- R3: When bit 31 of the index register (address 5) is set, the first stage is skipped entirely.
- R4: When control bit 2 (address 0) is set, a broadcast frame is dropped in whichever stage is active.
- R5: In the first stage, a multicast frame is dropped when control bit 1 is set. Otherwise it passes only if it equals one of four entries. The entries are read and written at addresses 6 (low word) and 7 (high word). The entry used is the one selected by bits 1:0 of the index register.
- R6: The second stage is active only when control bits 11 and 12 are both set. While it is active, a unicast frame must also equal the second station address (addresses 3 and 4).
- R7: While the second stage is active, a multicast frame that starts with 01-00-5E is dropped. Any other multicast frame forms the index ((byte4 & 0x7F) << 8) | byte5. It passes only if bit (index & 31) of table word (index >> 5) is set.
- R8: A frame of 1519 to 1522 bytes is dropped unless control bit 4 (jumbo) or control bit 5 (tagged) is set. Frame lengths just outside that band are not affected by this rule.
- R9: A frame shorter than 12 bytes is dropped and sets status bit 3 (address 8), which is shown on rej_flag_o.
- R10: Writing 1 to status bit 3 clears it. If a clearing write falls in the same cycle as a new reject, the flag stays set.
- R11: The decision (dec_valid_o with dec_accept_o and dec_class_o) is present for exactly one cycle, two clock edges after the edge that takes the last byte. It is never present at any other time. Read data appears on the edge that samples cfg_re_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Byte strobe |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_data_i | input | 8 | Frame byte |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_re_i | input | 1 | Register read strobe |
| cfg_addr_i | input | CFG_AW | Word address; top bit selects the hash table |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Registered read data |
| dec_valid_o | output | 1 | Decision pulse |
| dec_accept_o | output | 1 | Frame kept |
| dec_class_o | output | 2 | Frame class code |
| rej_flag_o | output | 1 | Sticky short-frame reject status |

## Verification
A short-frame reject and a software write that clears the reject status can arrive in the same cycle. The bench causes this by sending an 11-byte frame while a second branch issues the clear write. The write is timed so that it is sampled on the exact edge where the frame's decision registers. The expected result is that the flag stays set. A later plain clearing write must then bring the flag low. A behavioural model re-derives every verdict from a mirror of the configuration, and dec_valid_o is compared against that model on every clock.

// File: rtl/rx_addr_filter_pkg.sv
`timescale 1ns/1ps
package rx_addr_filter_pkg;
  localparam int unsigned N_MC    = 4;
  localparam int unsigned ENT_IW  = $clog2(N_MC);
  localparam int unsigned HASH_W  = 15;
  localparam int unsigned TBL_AW  = HASH_W - 5;
  localparam int unsigned TBL_WORDS = 2 ** TBL_AW;

  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_STA_LO = 1;
  localparam int unsigned REG_STA_HI = 2;
  localparam int unsigned REG_EXT_LO = 3;
  localparam int unsigned REG_EXT_HI = 4;
  localparam int unsigned REG_FIDX   = 5;
  localparam int unsigned REG_ENT_LO = 6;
  localparam int unsigned REG_ENT_HI = 7;
  localparam int unsigned REG_STAT   = 8;

  localparam int unsigned CTRL_MC_REJ = 1;
  localparam int unsigned CTRL_BC_REJ = 2;
  localparam int unsigned CTRL_JUMBO  = 4;
  localparam int unsigned CTRL_VLAN   = 5;
  localparam int unsigned CTRL_EXT_A  = 11;
  localparam int unsigned CTRL_EXT_B  = 12;
  localparam int unsigned FIDX_PROM   = 31;
  localparam int unsigned STAT_REJ    = 3;

  localparam logic [23:0] IPMC_PFX = 24'h5E0001;

  typedef enum logic [1:0] {
    CLS_UCAST = 2'd0,
    CLS_MCAST = 2'd1,
    CLS_BCAST = 2'd2
  } frame_class_e;

  typedef struct packed {
    logic        mc_rej;
    logic        bc_rej;
    logic        jumbo;
    logic        vlan;
    logic        ext_en;
    logic        promisc;
    logic [47:0] sta;
    logic [47:0] ext_sta;
  } filt_cfg_t;
endpackage

// File: rtl/rx_addr_filter_regs.sv
`timescale 1ns/1ps
module rx_addr_filter_regs
  import rx_addr_filter_pkg::*;
#(
  parameter int unsigned CFG_AW = 11
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic                   cfg_re_i,
  input  logic [CFG_AW-1:0]      cfg_addr_i,
  input  logic [31:0]            cfg_wdata_i,
  output logic [31:0]            cfg_rdata_o,
  input  logic                   tbl_re_i,
  input  logic [TBL_AW-1:0]      tbl_raddr_i,
  output logic [31:0]            tbl_word_o,
  input  logic                   rej_set_i,
  output logic                   rej_flag_o,
  output filt_cfg_t              cfg_o,
  output logic [47:0]            ent_o [N_MC]
);
  localparam int unsigned REG_AW = CFG_AW - 1;

  logic              tbl_sel;
  logic [REG_AW-1:0] reg_a;
  logic [TBL_AW-1:0] tbl_a;
  logic              reg_wr;

  assign tbl_sel = cfg_addr_i[CFG_AW-1];
  assign reg_a   = cfg_addr_i[REG_AW-1:0];
  assign tbl_a   = cfg_addr_i[TBL_AW-1:0];
  assign reg_wr  = cfg_we_i && !tbl_sel;

  logic [31:0]       ctrl_q, sta_lo_q, ext_lo_q;
  logic [15:0]       sta_hi_q, ext_hi_q;
  logic              prom_q;
  logic [ENT_IW-1:0] esel_q;
  logic [31:0]       ent_lo_q [N_MC];
  logic [15:0]       ent_hi_q [N_MC];
  logic              rej_q;
  logic [31:0]       tbl_mem [TBL_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      sta_lo_q <= '0;
      sta_hi_q <= '0;
      ext_lo_q <= '0;
      ext_hi_q <= '0;
      prom_q   <= 1'b0;
      esel_q   <= '0;
    end else if (reg_wr) begin
      case (reg_a)
        REG_AW'(REG_CTRL):   ctrl_q   <= cfg_wdata_i;
        REG_AW'(REG_STA_LO): sta_lo_q <= cfg_wdata_i;
        REG_AW'(REG_STA_HI): sta_hi_q <= cfg_wdata_i[15:0];
        REG_AW'(REG_EXT_LO): ext_lo_q <= cfg_wdata_i;
        REG_AW'(REG_EXT_HI): ext_hi_q <= cfg_wdata_i[15:0];
        REG_AW'(REG_FIDX): begin
          prom_q <= cfg_wdata_i[FIDX_PROM];
          esel_q <= cfg_wdata_i[ENT_IW-1:0];
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_MC; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_lo_q[g] <= '0;
        ent_hi_q[g] <= '0;
      end else if (reg_wr && esel_q == ENT_IW'(g)) begin
        if (reg_a == REG_AW'(REG_ENT_LO)) ent_lo_q[g] <= cfg_wdata_i;
        if (reg_a == REG_AW'(REG_ENT_HI)) ent_hi_q[g] <= cfg_wdata_i[15:0];
      end
    end
    assign ent_o[g] = {ent_hi_q[g], ent_lo_q[g]};
  end

  // a new reject outranks a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                                   rej_q <= 1'b0;
    else if (rej_set_i)                                            rej_q <= 1'b1;
    else if (reg_wr && reg_a == REG_AW'(REG_STAT) && cfg_wdata_i[STAT_REJ]) rej_q <= 1'b0;
  end
  assign rej_flag_o = rej_q;

  always_ff @(posedge clk_i) begin
    if (cfg_we_i && tbl_sel) tbl_mem[tbl_a] <= cfg_wdata_i;
    if (tbl_re_i)            tbl_word_o     <= tbl_mem[tbl_raddr_i];
  end

  logic [31:0] rd_d;
  always_comb begin
    rd_d = '0;
    case (reg_a)
      REG_AW'(REG_CTRL):   rd_d = ctrl_q;
      REG_AW'(REG_STA_LO): rd_d = sta_lo_q;
      REG_AW'(REG_STA_HI): rd_d = {16'h0, sta_hi_q};
      REG_AW'(REG_EXT_LO): rd_d = ext_lo_q;
      REG_AW'(REG_EXT_HI): rd_d = {16'h0, ext_hi_q};
      REG_AW'(REG_FIDX):   rd_d = {prom_q, {(31-ENT_IW){1'b0}}, esel_q};
      REG_AW'(REG_ENT_LO): rd_d = ent_lo_q[esel_q];
      REG_AW'(REG_ENT_HI): rd_d = {16'h0, ent_hi_q[esel_q]};
      REG_AW'(REG_STAT):   rd_d = 32'(rej_q) << STAT_REJ;
      default:             rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_rdata_o <= '0;
    else if (cfg_re_i) cfg_rdata_o <= tbl_sel ? tbl_mem[tbl_a] : rd_d;
  end

  always_comb begin
    cfg_o.mc_rej  = ctrl_q[CTRL_MC_REJ];
    cfg_o.bc_rej  = ctrl_q[CTRL_BC_REJ];
    cfg_o.jumbo   = ctrl_q[CTRL_JUMBO];
    cfg_o.vlan    = ctrl_q[CTRL_VLAN];
    cfg_o.ext_en  = ctrl_q[CTRL_EXT_A] && ctrl_q[CTRL_EXT_B];
    cfg_o.promisc = prom_q;
    cfg_o.sta     = {sta_hi_q, sta_lo_q};
    cfg_o.ext_sta = {ext_hi_q, ext_lo_q};
  end

  AST_REJ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_set_i |=> rej_flag_o); // R10
  AST_REJ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr && reg_a == REG_AW'(REG_STAT) && cfg_wdata_i[STAT_REJ] && !rej_set_i) |=> !rej_flag_o); // R10
endmodule

// File: rtl/rx_addr_filter_capture.sv
`timescale 1ns/1ps
module rx_addr_filter_capture
  import rx_addr_filter_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic [7:0]        data_i,
  output logic [47:0]       da_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              tbl_re_o,
  output logic [TBL_AW-1:0] tbl_raddr_o,
  output logic              pend_o
);
  localparam int unsigned DA_BYTES = 6;

  logic [LEN_W-1:0] cnt_q, idx;
  logic [47:0]      da_q;
  logic             pend_q;

  assign idx = sof_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      da_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= byte_valid_i && eof_i;
      if (byte_valid_i) begin
        if (sof_i)               cnt_q <= LEN_W'(1);
        else if (cnt_q != '1)    cnt_q <= cnt_q + LEN_W'(1);
        if (sof_i)               da_q  <= {40'h0, data_i};
        else if (idx < LEN_W'(DA_BYTES)) da_q[8*idx[2:0] +: 8] <= data_i;
      end
    end
  end

  // word = index >> 5 : byte4[6:0] and byte5[7:5]
  assign tbl_re_o    = byte_valid_i && !sof_i && idx == LEN_W'(DA_BYTES-1);
  assign tbl_raddr_o = {da_q[38:32], data_i[7:5]};
  assign da_o        = da_q;
  assign len_o       = cnt_q;
  assign pend_o      = pend_q;

  AST_LEN_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !sof_i) |=> cnt_q >= $past(cnt_q)); // R8
endmodule

// File: rtl/rx_addr_filter_decide.sv
`timescale 1ns/1ps
module rx_addr_filter_decide
  import rx_addr_filter_pkg::*;
#(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MIN_LEN = 12,
  parameter int unsigned STD_MAX = 1518,
  parameter int unsigned TAG_MAX = 1522
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pend_i,
  input  logic [47:0]      da_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [31:0]      tbl_word_i,
  input  filt_cfg_t        cfg_i,
  input  logic [47:0]      ent_i [N_MC],
  output logic             rej_set_o,
  output logic             dec_valid_o,
  output logic             dec_accept_o,
  output logic [1:0]       dec_class_o
);
  logic         is_bc, is_uc, ip_pfx, any_ent, hash_hit;
  logic [N_MC-1:0] ent_hit;
  frame_class_e cls;
  logic         basic_ok, ext_ok, runt, tag_band, len_ok;

  for (genvar g = 0; g < N_MC; g++) begin : g_hit
    assign ent_hit[g] = (da_i == ent_i[g]);
  end

  assign is_bc    = &da_i;
  assign is_uc    = !da_i[0];
  assign ip_pfx   = (da_i[23:0] == IPMC_PFX);
  assign any_ent  = |ent_hit;
  assign hash_hit = tbl_word_i[da_i[44:40]];
  assign cls      = is_bc ? CLS_BCAST : (is_uc ? CLS_UCAST : CLS_MCAST);

  always_comb begin
    if (cfg_i.promisc)  basic_ok = 1'b1;
    else if (is_bc)     basic_ok = !cfg_i.bc_rej;
    else if (is_uc)     basic_ok = (da_i == cfg_i.sta);
    else                basic_ok = !cfg_i.mc_rej && any_ent;
  end

  always_comb begin
    if (!cfg_i.ext_en)  ext_ok = 1'b1;
    else if (is_bc)     ext_ok = !cfg_i.bc_rej;
    else if (is_uc)     ext_ok = (da_i == cfg_i.ext_sta);
    else                ext_ok = !ip_pfx && hash_hit;
  end

  assign runt     = len_i < LEN_W'(MIN_LEN);
  assign tag_band = len_i > LEN_W'(STD_MAX) && len_i <= LEN_W'(TAG_MAX);
  assign len_ok   = !runt && !(tag_band && !cfg_i.jumbo && !cfg_i.vlan);
  assign rej_set_o = pend_i && runt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o  <= 1'b0;
      dec_accept_o <= 1'b0;
      dec_class_o  <= CLS_UCAST;
    end else begin
      dec_valid_o  <= pend_i;
      dec_accept_o <= pend_i && basic_ok && ext_ok && len_ok;
      if (pend_i) dec_class_o <= cls;
    end
  end

  AST_RUNT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && runt) |=> (dec_valid_o && !dec_accept_o)); // R9
  AST_BC_REJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && is_bc && cfg_i.bc_rej && (!cfg_i.promisc || cfg_i.ext_en))
      |=> (!dec_accept_o && dec_class_o == CLS_BCAST)); // R4
  AST_IPMC_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && cfg_i.ext_en && !is_bc && ip_pfx) |=> !dec_accept_o); // R7
  AST_CLASS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> dec_class_o != 2'd3); // R1
  AST_ACC_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_accept_o |-> dec_valid_o); // R11
endmodule

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int unsigned CFG_AW = 11,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic [7:0]        rx_data_i,
  input  logic              cfg_we_i,
  input  logic              cfg_re_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              dec_valid_o,
  output logic              dec_accept_o,
  output logic [1:0]        dec_class_o,
  output logic              rej_flag_o
);
  filt_cfg_t         cfg;
  logic [47:0]       ent [N_MC];
  logic [47:0]       da;
  logic [LEN_W-1:0]  len;
  logic              tbl_re, pend, rej_set;
  logic [TBL_AW-1:0] tbl_raddr;
  logic [31:0]       tbl_word;

  rx_addr_filter_regs #(.CFG_AW(CFG_AW)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_re_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .tbl_re_i(tbl_re), .tbl_raddr_i(tbl_raddr), .tbl_word_o(tbl_word),
    .rej_set_i(rej_set), .rej_flag_o, .cfg_o(cfg), .ent_o(ent)
  );

  rx_addr_filter_capture #(.LEN_W(LEN_W)) u_cap (
    .clk_i, .rst_ni, .byte_valid_i(rx_valid_i), .sof_i(rx_sof_i), .eof_i(rx_eof_i),
    .data_i(rx_data_i), .da_o(da), .len_o(len), .tbl_re_o(tbl_re),
    .tbl_raddr_o(tbl_raddr), .pend_o(pend)
  );

  rx_addr_filter_decide #(.LEN_W(LEN_W)) u_dec (
    .clk_i, .rst_ni, .pend_i(pend), .da_i(da), .len_i(len), .tbl_word_i(tbl_word),
    .cfg_i(cfg), .ent_i(ent), .rej_set_o(rej_set), .dec_valid_o, .dec_accept_o, .dec_class_o
  );

  AST_PULSE_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_eof_i) |=> ##1 dec_valid_o); // R11
endmodule

// File: tb/rx_addr_filter_tb.sv
`timescale 1ns/1ps
module rx_addr_filter_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0]  rx_data = 0;
  logic        cfg_we = 0, cfg_re = 0;
  logic [10:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        dec_valid, dec_accept, rej_flag;
  logic [1:0]  dec_class;

  always #2.5 clk = ~clk;

  rx_addr_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_sof_i(rx_sof),
    .rx_eof_i(rx_eof), .rx_data_i(rx_data), .cfg_we_i(cfg_we), .cfg_re_i(cfg_re),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .dec_valid_o(dec_valid), .dec_accept_o(dec_accept), .dec_class_o(dec_class),
    .rej_flag_o(rej_flag)
  );

  int n_chk = 0, n_fail = 0;
  bit in_dec = 0;

  logic [31:0] m_ctrl = 0, m_fidx = 0;
  logic [47:0] m_sta = 0, m_ext = 0;
  logic [47:0] m_ent [4] = '{default: '0};
  bit   [31:0] m_tbl [int];
  bit          m_rej = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R11: no decision outside the expected cycle
  always @(negedge clk) if (rst_n && !in_dec) chk("R11 idle", dec_valid, 0);

  task automatic cfg_wr(input logic [10:0] a, input logic [31:0] d);
    @(posedge clk); #1 cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 0;
    if (a[10]) m_tbl[int'(a[9:0])] = d;
    else case (a)
      0: m_ctrl = d;
      1: m_sta[31:0] = d;
      2: m_sta[47:32] = d[15:0];
      3: m_ext[31:0] = d;
      4: m_ext[47:32] = d[15:0];
      5: m_fidx = d;
      6: m_ent[m_fidx[1:0]][31:0] = d;
      7: m_ent[m_fidx[1:0]][47:32] = d[15:0];
      8: if (d[3]) m_rej = 0;
      default: ;
    endcase
  endtask

  task automatic cfg_rd(input logic [10:0] a, output logic [31:0] d);
    @(posedge clk); #1 cfg_re = 1; cfg_addr = a;
    @(posedge clk); #1 cfg_re = 0;
    d = cfg_rdata;
  endtask

  function automatic void model(input logic [47:0] d, input int len,
                                output bit acc, output logic [1:0] cls, output bit rj);
    logic [47:0] dm = d;
    bit uc, bc, ok;
    int idx;
    bit [31:0] w;
    for (int b = 0; b < 6; b++) if (b >= len) dm[8*b +: 8] = 8'h00;
    uc = !dm[0];
    bc = (dm == 48'hFFFF_FFFF_FFFF);
    cls = bc ? 2'd2 : (uc ? 2'd0 : 2'd1);
    ok = 1;
    if (!m_fidx[31]) begin
      if (bc) ok = !m_ctrl[2];
      else if (uc) ok = (dm == m_sta);
      else begin
        ok = 0;
        if (!m_ctrl[1]) for (int k = 0; k < 4; k++) if (dm == m_ent[k]) ok = 1;
      end
    end
    if (m_ctrl[11] && m_ctrl[12]) begin
      if (bc) ok = ok && !m_ctrl[2];
      else if (uc) ok = ok && (dm == m_ext);
      else if (dm[23:0] == 24'h5E0001) ok = 0;
      else begin
        idx = (int'(dm[38:32]) << 8) | int'(dm[47:40]);
        w = m_tbl.exists(idx / 32) ? m_tbl[idx / 32] : 32'h0;
        ok = ok && w[idx % 32];
      end
    end
    rj = (len < 12);
    if (rj) ok = 0;
    if (!m_ctrl[4] && !m_ctrl[5] && len >= 1519 && len <= 1522) ok = 0;
    acc = ok;
  endfunction

  task automatic drive_frame(input logic [47:0] d, input int len);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_data = (i < 6) ? d[8*i +: 8] : (8'(i) ^ 8'h5A);
    end
    @(posedge clk); #1 rx_valid = 0; rx_sof = 0; rx_eof = 0;
  endtask

  task automatic send(input string req, input logic [47:0] d, input int len);
    bit acc, rj;
    logic [1:0] cls;
    model(d, len, acc, cls, rj);
    if (rj) m_rej = 1;
    drive_frame(d, len);
    in_dec = 1;
    @(posedge clk);
    @(negedge clk);
    chk({req, " valid"}, dec_valid, 1);
    chk({req, " accept"}, dec_accept, acc);
    chk({req, " class"}, dec_class, cls);
    chk({req, " rej"}, rej_flag, m_rej);
    #1 in_dec = 0;
  endtask

  task automatic set_addr(input logic [10:0] lo_a, input logic [47:0] v);
    cfg_wr(lo_a, v[31:0]);
    cfg_wr(lo_a + 11'd1, {16'h0, v[47:32]});
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  localparam logic [47:0] UC_OK  = 48'h4433_2211_0002;
  localparam logic [47:0] UC_BAD = 48'h4434_2211_0002;
  localparam logic [47:0] BC     = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC_MISS= 48'h1234_5678_9A01;
  localparam logic [47:0] EXT_UC = 48'h0C0B_0A09_0806;
  localparam logic [47:0] IPMC   = 48'h3412_005E_0001;
  localparam logic [47:0] HMC_HIT= 48'h3412_005F_0001;
  localparam logic [47:0] HMC_B7 = 48'h3492_005F_0001;
  localparam logic [47:0] HMC_MIS= 48'h3512_005F_0001;

  function automatic logic [47:0] ent_val(input int k);
    return 48'h6655_4433_0001 + (48'(k) << 24);
  endfunction

  initial begin
    #(5 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R11 reset valid", dec_valid, 0);
    chk("R9 reset rej", rej_flag, 0);
    cfg_rd(11'd0, rd); chk("R2 reset ctrl", rd, 0);

    set_addr(11'd1, UC_OK);
    send("R2 uc match", UC_OK, 64);
    send("R2 uc miss", UC_BAD, 64);
    send("R1 bc class", BC, 64);
    cfg_wr(11'd0, 32'h4);
    send("R4 bc reject", BC, 64);
    cfg_wr(11'd0, 32'h0);

    for (int k = 0; k < 4; k++) begin
      cfg_wr(11'd5, k);
      set_addr(11'd6, ent_val(k));
    end
    cfg_wr(11'd5, 32'd2);
    cfg_rd(11'd6, rd); chk("R5 entry readback", rd, ent_val(2)[31:0]);
    cfg_rd(11'd7, rd); chk("R5 entry readback hi", rd, {16'h0, ent_val(2)[47:32]});
    send("R5 mc entry3", ent_val(3), 64);
    send("R5 mc entry0", ent_val(0), 64);
    send("R5 mc miss", MC_MISS, 64);
    cfg_wr(11'd0, 32'h2);
    send("R5 mc reject", ent_val(3), 64);
    cfg_wr(11'd0, 32'h0);

    cfg_wr(11'd5, 32'h8000_0000);
    send("R3 promisc uc", UC_BAD, 64);
    send("R3 promisc mc", MC_MISS, 64);

    set_addr(11'd3, EXT_UC);
    cfg_wr(11'h400 + 11'h91, 32'h1 << 20);
    cfg_wr(11'd0, 32'h800);
    send("R6 one ext bit", UC_BAD, 64);
    cfg_wr(11'd0, 32'h1800);
    send("R6 ext uc match", EXT_UC, 64);
    send("R6 ext uc miss", UC_OK, 64);
    send("R7 ipmc drop", IPMC, 64);
    send("R7 hash hit", HMC_HIT, 64);
    send("R7 hash bit7 masked", HMC_B7, 64);
    send("R7 hash miss", HMC_MIS, 64);
    cfg_wr(11'd0, 32'h1804);
    send("R4 ext bc reject", BC, 64);
    cfg_rd(11'h491, rd); chk("R7 table readback", rd, 32'h1 << 20);
    cfg_wr(11'd0, 32'h0);
    cfg_wr(11'd5, 32'h0);

    send("R8 1518", UC_OK, 1518);
    send("R8 1519", UC_OK, 1519);
    send("R8 1522", UC_OK, 1522);
    send("R8 1523", UC_OK, 1523);
    cfg_wr(11'd0, 32'h20);
    send("R8 tagged 1520", UC_OK, 1520);
    cfg_wr(11'd0, 32'h10);
    send("R8 jumbo 1521", UC_OK, 1521);
    cfg_wr(11'd0, 32'h0);

    send("R9 len12", UC_OK, 12);
    send("R9 len11", UC_OK, 11);
    cfg_wr(11'd8, 32'h8);
    @(negedge clk); chk("R10 clear", rej_flag, 0);
    cfg_rd(11'd8, rd); chk("R10 status read", rd, 0);
    send("R9 len4", MC_MISS, 4);
    cfg_wr(11'd8, 32'h7);
    @(negedge clk); chk("R10 other bits keep", rej_flag, 1);
    cfg_wr(11'd8, 32'h8);

    // R10: clearing write lands on the same edge as a new reject
    fork
      send("R10 set wins", UC_OK, 11);
      begin
        repeat (11) @(posedge clk);
        @(posedge clk); #1 cfg_we = 1; cfg_addr = 11'd8; cfg_wdata = 32'h8;
        @(posedge clk); #1 cfg_we = 0;
      end
    join
    @(negedge clk); chk("R10 set wins after", rej_flag, 1);
    cfg_wr(11'd8, 32'h8);
    @(negedge clk); chk("R10 later clear", rej_flag, 0);

    send("R11 single byte", UC_OK, 1);
    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule